// File: doc/BRIEF.md
# UART Receive Queue and Status Controller

This block sits between a UART deserialiser and the host side of a serial port. Each received character arrives with its break, framing-error and parity-error flags and goes into a four-entry queue. The host pops characters from the head of the queue. Status flags for those characters are reported in one of two ways. In per-character mode they follow the head entry. In accumulate mode they are a sticky OR over every character that has reached the head since the host last cleared status.

The block also does receiver-side flow control on an RTS output. RTS drops when a new character starts while the queue is already full, and it comes back once space frees up. A configuration bit picks what raises the receive request line: "data available" or "queue full".

Configuration lives in two 8-bit mode registers. The host reaches both through one access port, guided by an internal pointer. The pointer starts on the first register and moves to the second after any access to the first.

Top module: `uart_rxq_ctrl`

## Requirements
- R1: After reset the queue is empty, `rx_ready`, `fifo_full`, the status flags, `st_ovr` and `rx_req` are 0, `rts_o` is 1, the pointer selects mode register 1, and both mode registers read 0.
- R2: Accepted characters leave in arrival order. `head_data` shows the oldest one. `fifo_full` is 1 with 4 entries held and `rx_ready` is 1 with at least one. A pop on an empty queue is ignored.
- R3: A push while full, without a pop in the same cycle, discards the character and sets `st_ovr`.
- R4: With mode register 1 bit 5 at 0, `st_brk`/`st_fe`/`st_pe` equal the flags stored with the head character, and they are 0 when the queue is empty.
- R5: With mode register 1 bit 5 at 1, the status flags are the OR of the flags of every character that has become head since the last status clear.
- R6: `cmd_rst_err` clears the accumulated flags and `st_ovr` at the next edge. It wins over a head arrival or an overrun in the same cycle.
- R7: With mode register 1 bit 6 at 0, `rx_req` equals `rx_ready`. With it at 1, `rx_req` equals `fifo_full`.
- R8: With mode register 1 bit 7 at 1 and mode register 2 bit 5 at 0, `rx_start` in a cycle where the queue is full drives `rts_o` to 0 at the next edge.
- R9: `rts_o` returns to 1 at the first edge at which the queue is sampled not full.
- R10: If mode register 1 bit 7 is 0, or mode register 2 bit 5 (transmitter RTS control) is also 1, `rts_o` stays 1 whatever the queue and `rx_start` do.
- R11: `mr_rdata` shows the register the pointer selects. A read or write of mode register 1 moves the pointer to mode register 2. Accesses to mode register 2 leave it there. `cmd_rst_ptr` returns it to mode register 1 and wins over a same-cycle advance.
- R12: Mode register 1 keeps all 8 written bits: bit 7 receiver RTS enable, bit 6 request select, bit 5 status mode, bits 4:3 parity mode, bit 2 parity type, bits 1:0 character length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break flag of the character |
| rx_fe | input | 1 | Framing-error flag of the character |
| rx_pe | input | 1 | Parity-error flag of the character |
| rx_start | input | 1 | Valid start bit detected |
| pop | input | 1 | Host removes the head character |
| mr_rd | input | 1 | Read access to the selected mode register |
| mr_wr | input | 1 | Write access to the selected mode register |
| mr_wdata | input | 8 | Mode register write data |
| cmd_rst_ptr | input | 1 | Return mode pointer to register 1 |
| cmd_rst_err | input | 1 | Clear accumulated status and overrun |
| mr_rdata | output | 8 | Selected mode register contents |
| head_data | output | 8 | Character at the queue head |
| rx_ready | output | 1 | Queue holds at least one character |
| fifo_full | output | 1 | Queue holds four characters |
| st_brk | output | 1 | Break status |
| st_fe | output | 1 | Framing-error status |
| st_pe | output | 1 | Parity-error status |
| st_ovr | output | 1 | Overrun status |
| rts_o | output | 1 | Request-to-send, 1 = asserted |
| rx_req | output | 1 | Receive interrupt/DMA request |

## Verification
The assertions assume that the strobes are clean single-cycle levels sampled at the clock edge, and that `rx_start`, `rx_push` and `pop` may come in any combination, including a push and a pop together on a full queue. The random stimulus draws every strobe on its own in each cycle. It keeps mode-register writes and both commands rare so that long runs in each status and request mode occur. The directed part forces the exact coincidences the properties depend on: a start while full, an overrun without a pop, and a clear in the same cycle as a head arrival.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rxq_entry_t;

    typedef struct packed {
        logic       rts_en;
        logic       irq_full;
        logic       blk_err;
        logic [1:0] par_mode;
        logic       par_type;
        logic [1:0] char_bits;
    } mr1_t;

    localparam int MR2_TXRTS_BIT = 5;

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t wr_entry,
    output rxq_entry_t head,
    output rxq_entry_t nxt_head,
    output logic       empty,
    output logic       full,
    output logic       drop,
    output logic       arrive
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]          rd;
        logic [AW-1:0]          wr;
        logic [CW-1:0]          cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic pop_ok, acc_ok;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && (st_q.cnt != '0);
        acc_ok = push && ((st_q.cnt != CW'(DEPTH)) || pop_ok);
        if (acc_ok) begin
            st_d.mem[st_q.wr] = wr_entry;
            st_d.wr           = wrap_inc(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = wrap_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(acc_ok) - CW'(pop_ok);

        head     = st_q.mem[st_q.rd];
        nxt_head = (pop_ok && (st_q.cnt > CW'(1))) ? st_q.mem[wrap_inc(st_q.rd)] : wr_entry;
        empty    = (st_q.cnt == '0);
        full     = (st_q.cnt == CW'(DEPTH));
        drop     = push && !acc_ok;
        arrive   = (acc_ok && (st_q.cnt == '0)) ||
                   (pop_ok && ((st_q.cnt > CW'(1)) || acc_ok));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxq_status.sv
module rxq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_mode,
    input  logic       clr,
    input  logic       arrive,
    input  logic [2:0] nxt_flags,
    input  logic [2:0] head_flags,
    input  logic       nonempty,
    input  logic       drop,
    output logic [2:0] flags,
    output logic       ovr
);
    typedef struct packed {
        logic [2:0] acc;
        logic       ovr;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
            st_d.ovr = 1'b0;
        end else begin
            if (arrive) st_d.acc = st_q.acc | nxt_flags;
            if (drop)   st_d.ovr = 1'b1;
        end
        flags = blk_mode ? st_q.acc : (nonempty ? head_flags : 3'b000);
        ovr   = st_q.ovr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_on,
    input  logic irq_full,
    input  logic start,
    input  logic full,
    input  logic empty,
    output logic rts,
    output logic req
);
    typedef struct packed {
        logic rts;
    } flow_st_t;

    flow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ctl_on)            st_d.rts = 1'b1;
        else if (start && full) st_d.rts = 1'b0;
        else if (!full)         st_d.rts = 1'b1;
        rts = st_q.rts;
        req = irq_full ? full : !empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{rts: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxq_modes.sv
module rxq_modes
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       rst_ptr,
    output logic [7:0] rdata,
    output logic       ptr,
    output logic       rts_en,
    output logic       irq_full,
    output logic       blk_err,
    output logic       tx_rts_en
);
    typedef struct packed {
        logic       ptr;
        mr1_t       mr1;
        logic [7:0] mr2;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (!st_q.ptr) st_d.mr1 = mr1_t'(wdata);
            else           st_d.mr2 = wdata;
        end
        if ((rd || wr) && !st_q.ptr) st_d.ptr = 1'b1;
        if (rst_ptr)                 st_d.ptr = 1'b0;

        rdata     = st_q.ptr ? st_q.mr2 : st_q.mr1;
        ptr       = st_q.ptr;
        rts_en    = st_q.mr1.rts_en;
        irq_full  = st_q.mr1.irq_full;
        blk_err   = st_q.mr1.blk_err;
        tx_rts_en = st_q.mr2[MR2_TXRTS_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    input  logic       rx_brk,
    input  logic       rx_fe,
    input  logic       rx_pe,
    input  logic       rx_start,
    input  logic       pop,
    input  logic       mr_rd,
    input  logic       mr_wr,
    input  logic [7:0] mr_wdata,
    input  logic       cmd_rst_ptr,
    input  logic       cmd_rst_err,
    output logic [7:0] mr_rdata,
    output logic [7:0] head_data,
    output logic       rx_ready,
    output logic       fifo_full,
    output logic       st_brk,
    output logic       st_fe,
    output logic       st_pe,
    output logic       st_ovr,
    output logic       rts_o,
    output logic       rx_req
);
    rxq_entry_t in_entry, head, nxt_head;
    logic       q_empty, q_full, q_drop, q_arrive;
    logic       mr_ptr, rts_en, irq_full, blk_err, tx_rts_en, rts_ctl_on;
    logic [2:0] flags;

    assign in_entry   = '{brk: rx_brk, fe: rx_fe, pe: rx_pe, data: rx_data};
    assign rts_ctl_on = rts_en && !tx_rts_en;

    rxq_modes u_modes (
        .clk(clk), .rst_n(rst_n), .rd(mr_rd), .wr(mr_wr), .wdata(mr_wdata),
        .rst_ptr(cmd_rst_ptr), .rdata(mr_rdata), .ptr(mr_ptr), .rts_en(rts_en),
        .irq_full(irq_full), .blk_err(blk_err), .tx_rts_en(tx_rts_en)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(pop), .wr_entry(in_entry),
        .head(head), .nxt_head(nxt_head), .empty(q_empty), .full(q_full),
        .drop(q_drop), .arrive(q_arrive)
    );

    rxq_status u_status (
        .clk(clk), .rst_n(rst_n), .blk_mode(blk_err), .clr(cmd_rst_err),
        .arrive(q_arrive), .nxt_flags({nxt_head.brk, nxt_head.fe, nxt_head.pe}),
        .head_flags({head.brk, head.fe, head.pe}), .nonempty(!q_empty),
        .drop(q_drop), .flags(flags), .ovr(st_ovr)
    );

    rxq_flow u_flow (
        .clk(clk), .rst_n(rst_n), .ctl_on(rts_ctl_on), .irq_full(irq_full),
        .start(rx_start), .full(q_full), .empty(q_empty), .rts(rts_o), .req(rx_req)
    );

    assign head_data = head.data;
    assign rx_ready  = !q_empty;
    assign fifo_full = q_full;
    assign {st_brk, st_fe, st_pe} = flags;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_push,
    input logic pop,
    input logic rx_start,
    input logic cmd_rst_err,
    input logic cmd_rst_ptr,
    input logic fifo_full,
    input logic rx_ready,
    input logic st_ovr,
    input logic rts_o,
    input logic rx_req,
    input logic rts_ctl_on,
    input logic mr_ptr
);
    a_r2_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_ready);

    a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && fifo_full && !pop && !cmd_rst_err) |=> st_ovr);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_err |=> !st_ovr);

    a_r7_full_requests: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_req);

    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> !rx_req);

    a_r8_rts_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_ctl_on && rx_start && fifo_full) |=> !rts_o);

    a_r9_rts_return: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_full |=> rts_o);

    a_r10_rts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_ctl_on |=> rts_o);

    a_r11_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_ptr |=> !mr_ptr);
endmodule

bind uart_rxq_ctrl uart_rxq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .pop(pop), .rx_start(rx_start),
    .cmd_rst_err(cmd_rst_err), .cmd_rst_ptr(cmd_rst_ptr), .fifo_full(fifo_full),
    .rx_ready(rx_ready), .st_ovr(st_ovr), .rts_o(rts_o), .rx_req(rx_req),
    .rts_ctl_on(rts_ctl_on), .mr_ptr(mr_ptr)
);

// File: tb/uart_rxq_ctrl_tb.sv
module uart_rxq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_brk = 0, rx_fe = 0, rx_pe = 0, rx_start = 0, pop = 0;
    logic       mr_rd = 0, mr_wr = 0, cmd_rst_ptr = 0, cmd_rst_err = 0;
    logic [7:0] rx_data = 0, mr_wdata = 0;
    logic [7:0] mr_rdata, head_data;
    logic       rx_ready, fifo_full, st_brk, st_fe, st_pe, st_ovr, rts_o, rx_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [10:0] mq[$];
    logic [2:0]  m_acc;
    logic        m_ovr, m_rts, m_ptr;
    logic [7:0]  m_mr1, m_mr2;

    always #10 clk = ~clk;

    uart_rxq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data), .rx_brk(rx_brk),
        .rx_fe(rx_fe), .rx_pe(rx_pe), .rx_start(rx_start), .pop(pop), .mr_rd(mr_rd),
        .mr_wr(mr_wr), .mr_wdata(mr_wdata), .cmd_rst_ptr(cmd_rst_ptr),
        .cmd_rst_err(cmd_rst_err), .mr_rdata(mr_rdata), .head_data(head_data),
        .rx_ready(rx_ready), .fifo_full(fifo_full), .st_brk(st_brk), .st_fe(st_fe),
        .st_pe(st_pe), .st_ovr(st_ovr), .rts_o(rts_o), .rx_req(rx_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [2:0] exp_flags();
        if (m_mr1[5]) return m_acc;
        return (mq.size() > 0) ? mq[0][10:8] : 3'b000;
    endfunction

    task automatic compare_all();
        logic exp_full;
        exp_full = (mq.size() == 4);
        check("R2 rx_ready", rx_ready, mq.size() > 0);
        check("R2 fifo_full", fifo_full, exp_full);
        if (mq.size() > 0) check("R2 head_data", head_data, mq[0][7:0]);
        check(m_mr1[5] ? "R5 status" : "R4 status", {st_brk, st_fe, st_pe}, exp_flags());
        check("R3 st_ovr", st_ovr, m_ovr);
        check("R7 rx_req", rx_req, m_mr1[6] ? exp_full : (mq.size() > 0));
        check("R8 rts_o", rts_o, m_rts);
        check("R11 mr_rdata", mr_rdata, m_ptr ? m_mr2 : m_mr1);
    endtask

    // Apply current inputs for one edge, advance the model, compare after the edge.
    task automatic step();
        logic pop_ok, accept, arrive, full_old, active;
        int   old_n;
        old_n    = mq.size();
        full_old = (old_n == 4);
        pop_ok   = pop && (old_n > 0);
        accept   = rx_push && (!full_old || pop_ok);
        active   = m_mr1[7] && !m_mr2[5];
        if (!active)                   m_rts = 1'b1;
        else if (rx_start && full_old) m_rts = 1'b0;
        else if (!full_old)            m_rts = 1'b1;
        if (pop_ok) void'(mq.pop_front());
        if (accept) mq.push_back({rx_brk, rx_fe, rx_pe, rx_data});
        arrive = (mq.size() > 0) && ((old_n == 0) || pop_ok);
        if (cmd_rst_err) begin
            m_acc = 3'b000;
            m_ovr = 1'b0;
        end else begin
            if (arrive) m_acc = m_acc | mq[0][10:8];
            if (rx_push && !accept) m_ovr = 1'b1;
        end
        if (mr_wr) begin
            if (!m_ptr) m_mr1 = mr_wdata;
            else        m_mr2 = mr_wdata;
        end
        if ((mr_rd || mr_wr) && !m_ptr) m_ptr = 1'b1;
        if (cmd_rst_ptr) m_ptr = 1'b0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        rx_push = 0; rx_start = 0; pop = 0; mr_rd = 0; mr_wr = 0;
        cmd_rst_ptr = 0; cmd_rst_err = 0;
    endtask

    task automatic push_char(input logic [7:0] d, input logic [2:0] f);
        idle_inputs();
        rx_push = 1; rx_data = d; {rx_brk, rx_fe, rx_pe} = f;
        step();
        idle_inputs();
    endtask

    task automatic write_mr(input logic [7:0] v);
        idle_inputs();
        mr_wr = 1; mr_wdata = v;
        step();
        idle_inputs();
    endtask

    task automatic do_pop();
        idle_inputs();
        pop = 1;
        step();
        idle_inputs();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL R1 watchdog expired actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        mq.delete();
        m_acc = 0; m_ovr = 0; m_rts = 1; m_ptr = 0; m_mr1 = 0; m_mr2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rx_ready", rx_ready, 0);
        check("R1 fifo_full", fifo_full, 0);
        check("R1 status", {st_brk, st_fe, st_pe, st_ovr}, 0);
        check("R1 rts_o", rts_o, 1);
        check("R1 rx_req", rx_req, 0);
        check("R1 mr_rdata", mr_rdata, 0);

        // R12: all fields of mode register 1 retained; pointer then at MR2
        write_mr(8'h5B);
        idle_inputs(); cmd_rst_ptr = 1; step(); idle_inputs();
        check("R12 mr1 fields", mr_rdata, 8'h5B);
        idle_inputs(); mr_rd = 1; step(); idle_inputs();
        check("R11 ptr after mr1 read", mr_rdata, 0);
        idle_inputs(); mr_rd = 1; step(); idle_inputs();
        check("R11 ptr stays on mr2", mr_rdata, 0);
        // R11: reset-pointer wins over a same-cycle access
        idle_inputs(); cmd_rst_ptr = 1; mr_rd = 1; step(); idle_inputs();
        idle_inputs(); cmd_rst_ptr = 1; mr_rd = 1; step(); idle_inputs();
        check("R11 cmd priority", mr_rdata, 8'h5B);

        // Character mode with receiver RTS control
        write_mr(8'h80);
        idle_inputs(); cmd_rst_ptr = 1; step(); idle_inputs();
        push_char(8'h11, 3'b100);
        push_char(8'h22, 3'b010);
        push_char(8'h33, 3'b001);
        push_char(8'h44, 3'b000);
        check("R2 full at four", fifo_full, 1);
        push_char(8'h55, 3'b111);
        check("R3 overrun flag", st_ovr, 1);
        idle_inputs(); rx_start = 1; step(); idle_inputs();
        check("R8 rts negated", rts_o, 0);
        do_pop();
        check("R4 head flags", {st_brk, st_fe, st_pe}, 3'b010);
        idle_inputs(); step();
        check("R9 rts reasserted", rts_o, 1);
        repeat (4) do_pop();
        check("R2 empty pop ignored", rx_ready, 0);

        // Block mode with request on full
        write_mr(8'hE0);
        idle_inputs(); cmd_rst_err = 1; step(); idle_inputs();
        // R6: clear in the same cycle as a head arrival
        idle_inputs(); rx_push = 1; rx_data = 8'h66; {rx_brk, rx_fe, rx_pe} = 3'b111;
        cmd_rst_err = 1; step(); idle_inputs();
        check("R6 clear beats arrival", {st_brk, st_fe, st_pe, st_ovr}, 0);
        push_char(8'h77, 3'b001);
        do_pop();
        check("R5 accumulated", {st_brk, st_fe, st_pe}, 3'b001);

        // R10: transmitter also claims RTS, receiver control disabled
        idle_inputs(); mr_rd = 1; step(); idle_inputs();
        write_mr(8'h20);
        repeat (4) push_char(8'h88, 3'b000);
        idle_inputs(); rx_start = 1; step(); idle_inputs();
        check("R10 rts held", rts_o, 1);

        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            rx_push     = ($urandom % 3) == 0;
            rx_data     = 8'($urandom);
            {rx_brk, rx_fe, rx_pe} = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            rx_start    = ($urandom % 3) == 0;
            pop         = ($urandom % 4) == 0;
            mr_rd       = ($urandom % 25) == 0;
            mr_wr       = ($urandom % 40) == 0;
            mr_wdata    = 8'($urandom);
            cmd_rst_ptr = ($urandom % 30) == 0;
            cmd_rst_err = ($urandom % 35) == 0;
            step();
        end
        idle_inputs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule